// File: doc/BRIEF.md
# USB Token Address and Endpoint Filter

This block sits behind the packet decoder of a USB device-side serial engine. For each decoded token it gets a strobe, the 4-bit packet identifier, the 7-bit device address and the 4-bit endpoint number. It then decides whether the device has to answer that token. When it does, it reports which address slot matched, the endpoint, and the transfer direction.

Four address slots are compared in parallel. Slot 0 holds the device's local address and slots 1 to 3 hold alternate addresses, for example for an embedded hub function. Each slot has its own valid bit. Two per-direction endpoint masks decide which endpoints may take part. A receive-all (snoop) mode accepts tokens for any device address. All of this configuration is written through a small write port and can be changed while traffic is running.

The decision is made by a three-state machine. ST_IDLE means no token was seen in the previous cycle. ST_ACCEPT means the previous cycle carried an accepted token, and it drives the match pulse. ST_REJECT means the previous cycle carried a token that was turned down. On every cycle the next state is chosen from the current inputs alone. A strobe with an accepted token leads to ST_ACCEPT (transition T_ACC). A strobe with a rejected token leads to ST_REJECT (T_REJ). No strobe leads to ST_IDLE (T_QUIET). These three transitions apply from every state, so back-to-back tokens are handled one per cycle.

Top module: `usb_token_filter`

## Requirements
- R1: There are four address slots: slot 0 is the local address and slots 1 to 3 are alternates. A write with `cfg_sel_i` = n (0..3) sets slot n: `cfg_data_i[6:0]` is the address and `cfg_data_i[7]` is the valid bit. A token whose address equals a valid slot's address is accepted, as long as its endpoint is enabled.
- R2: A slot whose valid bit is clear never produces a match, even when its stored address equals the token address.
- R3: When several valid slots hold the token's address, `match_idx_o` reports the lowest-numbered one (0..3).
- R4: IN tokens are checked against the transmit mask, written with `cfg_sel_i` = 4. OUT and SETUP tokens are checked against the receive mask, written with `cfg_sel_i` = 5. Bit n of a mask enables endpoint n, and a token for a disabled endpoint is not matched.
- R5: Packet identifier codes are: OUT = 4'b0001, IN = 4'b1001, SETUP = 4'b1101. Any other code (for example SOF = 4'b0101) never matches.
- R6: When receive-all mode is on (`cfg_sel_i` = 6, `cfg_data_i[0]` = 1), tokens for any address are accepted, subject to the endpoint masks. In this mode `match_idx_o` is 4, the snoop code.
- R7: `match_o` is high for exactly one cycle. It rises on the clock edge that follows the cycle in which `tok_valid_i` was high with an accepted token. In that same cycle `match_ep_o` gives the endpoint and `match_dir_o` gives the direction (1 = IN / transmit, 0 = OUT or SETUP / receive). Tokens on consecutive cycles produce one result each.
- R8: A configuration write takes effect for tokens presented from the cycle after the write. No reset is needed.
- R9: After reset all slots are invalid, both masks are zero and receive-all is off. No token matches, and `match_o`, `match_idx_o`, `match_ep_o` and `match_dir_o` are 0.
- R10: When `match_o` is low, `match_idx_o`, `match_ep_o` and `match_dir_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_sel_i | input | 3 | Configuration target: 0-3 slot, 4 transmit mask, 5 receive mask, 6 receive-all |
| cfg_data_i | input | 16 | Configuration write data |
| tok_valid_i | input | 1 | Token fields valid this cycle |
| tok_pid_i | input | 4 | Token packet identifier |
| tok_addr_i | input | 7 | Token device address |
| tok_ep_i | input | 4 | Token endpoint number |
| match_o | output | 1 | One-cycle pulse: respond to the token |
| match_idx_o | output | 3 | Matched slot 0-3, or 4 in receive-all mode |
| match_ep_o | output | 4 | Endpoint of the matched token |
| match_dir_o | output | 1 | 1 = IN (transmit), 0 = OUT/SETUP (receive) |

## Verification
The filter is driven with tokens whose address hits the local slot, an alternate slot, several slots at once, only an invalid slot, or no slot at all. These cases separate the compare from the valid gating and from the priority order. The same addresses are then sent with IN, OUT, SETUP and SOF codes under masks that enable one direction but not the other, which shows that each direction's mask is chosen from the packet identifier. Snoop mode is tried with a foreign address under both an enabling and a blocking mask. Masks are also rewritten between tokens, and tokens are sent back-to-back, to expose write-to-use timing and any result lost or merged across consecutive strobes.

// File: rtl/tokfilt_pkg.sv
package tokfilt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCEPT = 2'd1,
        ST_REJECT = 2'd2
    } filt_state_e;

    typedef enum logic [3:0] {
        PID_OUT   = 4'b0001,
        PID_IN    = 4'b1001,
        PID_SETUP = 4'b1101
    } tok_pid_e;

    localparam logic [2:0] SEL_TXMASK = 3'd4;
    localparam logic [2:0] SEL_RXMASK = 3'd5;
    localparam logic [2:0] SEL_SNOOP  = 3'd6;

    function automatic logic pid_is_in(input logic [3:0] pid);
        return pid == PID_IN;
    endfunction

    function automatic logic pid_is_rx(input logic [3:0] pid);
        return (pid == PID_OUT) || (pid == PID_SETUP);
    endfunction

endpackage

// File: rtl/tokfilt_cfg_regs.sv
module tokfilt_cfg_regs #(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 7,
    parameter int NUM_EP    = 16,
    parameter int SEL_W     = 3
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          we_i,
    input  logic [SEL_W-1:0]              sel_i,
    input  logic [NUM_EP-1:0]             data_i,
    output logic [NUM_SLOTS*ADDR_W-1:0]   slot_addr_o,
    output logic [NUM_SLOTS-1:0]          slot_vld_o,
    output logic [NUM_EP-1:0]             tx_mask_o,
    output logic [NUM_EP-1:0]             rx_mask_o,
    output logic                          snoop_o
);
    import tokfilt_pkg::*;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                slot_addr_o[s*ADDR_W +: ADDR_W] <= '0;
                slot_vld_o[s]                   <= 1'b0;
            end else if (we_i && (sel_i == SEL_W'(s))) begin
                slot_addr_o[s*ADDR_W +: ADDR_W] <= data_i[ADDR_W-1:0];
                slot_vld_o[s]                   <= data_i[ADDR_W];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            tx_mask_o <= '0;
            rx_mask_o <= '0;
            snoop_o   <= 1'b0;
        end else if (we_i) begin
            if (sel_i == SEL_TXMASK) tx_mask_o <= data_i;
            if (sel_i == SEL_RXMASK) rx_mask_o <= data_i;
            if (sel_i == SEL_SNOOP)  snoop_o   <= data_i[0];
        end
    end

endmodule

// File: rtl/tokfilt_addr_cmp.sv
module tokfilt_addr_cmp #(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 7,
    localparam int IDX_W    = $clog2(NUM_SLOTS + 1)
) (
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic [NUM_SLOTS*ADDR_W-1:0]  slot_addr_i,
    input  logic [NUM_SLOTS-1:0]         slot_vld_i,
    output logic                         hit_o,
    output logic [IDX_W-1:0]             idx_o
);
    logic [NUM_SLOTS-1:0] hit_vec;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cmp
        assign hit_vec[s] = slot_vld_i[s] &&
                            (slot_addr_i[s*ADDR_W +: ADDR_W] == addr_i);
    end

    assign hit_o = |hit_vec;

    always_comb begin
        idx_o = '0;
        for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
            if (hit_vec[s]) idx_o = IDX_W'(s);
        end
    end

endmodule

// File: rtl/tokfilt_ep_gate.sv
module tokfilt_ep_gate #(
    parameter int NUM_EP = 16,
    localparam int EP_W  = $clog2(NUM_EP)
) (
    input  logic [3:0]        pid_i,
    input  logic [EP_W-1:0]   ep_i,
    input  logic [NUM_EP-1:0] tx_mask_i,
    input  logic [NUM_EP-1:0] rx_mask_i,
    output logic              ok_o,
    output logic              is_in_o
);
    import tokfilt_pkg::*;

    logic is_rx;

    assign is_in_o = pid_is_in(pid_i);
    assign is_rx   = pid_is_rx(pid_i);
    assign ok_o    = (is_in_o && tx_mask_i[ep_i]) || (is_rx && rx_mask_i[ep_i]);

endmodule

// File: rtl/usb_token_filter.sv
module usb_token_filter #(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 7,
    parameter int NUM_EP    = 16,
    localparam int EP_W     = $clog2(NUM_EP),
    localparam int IDX_W    = $clog2(NUM_SLOTS + 1),
    localparam int SEL_W    = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_we_i,
    input  logic [SEL_W-1:0]  cfg_sel_i,
    input  logic [NUM_EP-1:0] cfg_data_i,
    input  logic              tok_valid_i,
    input  logic [3:0]        tok_pid_i,
    input  logic [ADDR_W-1:0] tok_addr_i,
    input  logic [EP_W-1:0]   tok_ep_i,
    output logic              match_o,
    output logic [IDX_W-1:0]  match_idx_o,
    output logic [EP_W-1:0]   match_ep_o,
    output logic              match_dir_o
);
    import tokfilt_pkg::*;

    localparam logic [IDX_W-1:0] SNOOP_IDX = IDX_W'(NUM_SLOTS);

    logic [NUM_SLOTS*ADDR_W-1:0] slot_addr_w;
    logic [NUM_SLOTS-1:0]        slot_vld_w;
    logic [NUM_EP-1:0]           tx_mask_w;
    logic [NUM_EP-1:0]           rx_mask_w;
    logic                        snoop_w;
    logic                        addr_hit_w;
    logic [IDX_W-1:0]            addr_idx_w;
    logic                        ep_ok_w;
    logic                        is_in_w;
    logic                        accept_w;

    filt_state_e     state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [EP_W-1:0]  ep_q;
    logic             dir_q;

    tokfilt_cfg_regs #(
        .NUM_SLOTS (NUM_SLOTS),
        .ADDR_W    (ADDR_W),
        .NUM_EP    (NUM_EP),
        .SEL_W     (SEL_W)
    ) u_cfg (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .we_i        (cfg_we_i),
        .sel_i       (cfg_sel_i),
        .data_i      (cfg_data_i),
        .slot_addr_o (slot_addr_w),
        .slot_vld_o  (slot_vld_w),
        .tx_mask_o   (tx_mask_w),
        .rx_mask_o   (rx_mask_w),
        .snoop_o     (snoop_w)
    );

    tokfilt_addr_cmp #(
        .NUM_SLOTS (NUM_SLOTS),
        .ADDR_W    (ADDR_W)
    ) u_cmp (
        .addr_i      (tok_addr_i),
        .slot_addr_i (slot_addr_w),
        .slot_vld_i  (slot_vld_w),
        .hit_o       (addr_hit_w),
        .idx_o       (addr_idx_w)
    );

    tokfilt_ep_gate #(
        .NUM_EP (NUM_EP)
    ) u_ep (
        .pid_i     (tok_pid_i),
        .ep_i      (tok_ep_i),
        .tx_mask_i (tx_mask_w),
        .rx_mask_i (rx_mask_w),
        .ok_o      (ep_ok_w),
        .is_in_o   (is_in_w)
    );

    assign accept_w = ep_ok_w && (snoop_w || addr_hit_w);

    // Next-state choice: T_ACC, T_REJ or T_QUIET, the same from every state
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_ACCEPT, ST_REJECT: begin
                if (tok_valid_i && accept_w)  state_d = ST_ACCEPT;
                else if (tok_valid_i)         state_d = ST_REJECT;
                else                          state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and captured result fields
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            ep_q    <= '0;
            dir_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (tok_valid_i && accept_w) begin
                idx_q <= snoop_w ? SNOOP_IDX : addr_idx_w;
                ep_q  <= tok_ep_i;
                dir_q <= is_in_w;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        match_o     = 1'b0;
        match_idx_o = '0;
        match_ep_o  = '0;
        match_dir_o = 1'b0;
        unique case (state_q)
            ST_ACCEPT: begin
                match_o     = 1'b1;
                match_idx_o = idx_q;
                match_ep_o  = ep_q;
                match_dir_o = dir_q;
            end
            ST_IDLE, ST_REJECT: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/tokfilt_checker.sv
module tokfilt_checker #(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 7,
    parameter int NUM_EP    = 16,
    localparam int EP_W     = $clog2(NUM_EP),
    localparam int IDX_W    = $clog2(NUM_SLOTS + 1)
) (
    input logic                         clk_i,
    input logic                         rst_ni,
    input logic                         tok_valid_i,
    input logic [3:0]                   tok_pid_i,
    input logic [ADDR_W-1:0]            tok_addr_i,
    input logic [EP_W-1:0]              tok_ep_i,
    input logic                         match_o,
    input logic [IDX_W-1:0]             match_idx_o,
    input logic [EP_W-1:0]              match_ep_o,
    input logic                         match_dir_o,
    input logic [NUM_SLOTS*ADDR_W-1:0]  slot_addr_w,
    input logic [NUM_SLOTS-1:0]         slot_vld_w,
    input logic                         snoop_w
);
    logic [NUM_SLOTS*ADDR_W-1:0] addr_d;
    logic [NUM_SLOTS-1:0]        vld_d;
    logic                        snoop_d;
    logic [ADDR_W-1:0]           tok_addr_d;

    always_ff @(posedge clk_i) begin
        addr_d     <= slot_addr_w;
        vld_d      <= slot_vld_w;
        snoop_d    <= snoop_w;
        tok_addr_d <= tok_addr_i;
    end

    a_r7_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_o |-> $past(tok_valid_i));

    a_r7_echo_ep: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_o |-> match_ep_o == $past(tok_ep_i));

    a_r4_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_o |-> match_dir_o == ($past(tok_pid_i) == 4'b1001));

    a_r5_bad_pid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tok_valid_i && tok_pid_i != 4'b0001 && tok_pid_i != 4'b1001 &&
         tok_pid_i != 4'b1101) |=> !match_o);

    a_r6_snoop_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (match_o && snoop_d) |-> match_idx_o == IDX_W'(NUM_SLOTS));

    a_r2_valid_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (match_o && !snoop_d) |-> (match_idx_o < IDX_W'(NUM_SLOTS)) &&
                                  vld_d[match_idx_o[IDX_W-2:0]]);

    a_r1_addr_eq: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (match_o && !snoop_d) |->
            addr_d[match_idx_o[IDX_W-2:0]*ADDR_W +: ADDR_W] == tok_addr_d);

    a_r10_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !match_o |-> (match_idx_o == '0 && match_ep_o == '0 && !match_dir_o));

endmodule

bind usb_token_filter tokfilt_checker #(
    .NUM_SLOTS (NUM_SLOTS),
    .ADDR_W    (ADDR_W),
    .NUM_EP    (NUM_EP)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tok_valid_i (tok_valid_i),
    .tok_pid_i   (tok_pid_i),
    .tok_addr_i  (tok_addr_i),
    .tok_ep_i    (tok_ep_i),
    .match_o     (match_o),
    .match_idx_o (match_idx_o),
    .match_ep_o  (match_ep_o),
    .match_dir_o (match_dir_o),
    .slot_addr_w (slot_addr_w),
    .slot_vld_w  (slot_vld_w),
    .snoop_w     (snoop_w)
);

// File: tb/usb_token_filter_test.sv
module usb_token_filter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [15:0] cfg_data = '0;
    logic        tok_valid = 1'b0;
    logic [3:0]  tok_pid = '0;
    logic [6:0]  tok_addr = '0;
    logic [3:0]  tok_ep = '0;
    logic        match;
    logic [2:0]  match_idx;
    logic [3:0]  match_ep;
    logic        match_dir;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    typedef struct {
        int          due;
        logic        hit;
        logic [2:0]  idx;
        logic [3:0]  ep;
        logic        dir;
        string       req;
    } exp_t;
    exp_t q[$];

    logic [6:0]  m_addr [4];
    logic        m_vld  [4];
    logic [15:0] m_tx = '0, m_rx = '0;
    logic        m_all = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    usb_token_filter uut (
        .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
        .cfg_data_i(cfg_data), .tok_valid_i(tok_valid), .tok_pid_i(tok_pid),
        .tok_addr_i(tok_addr), .tok_ep_i(tok_ep), .match_o(match),
        .match_idx_o(match_idx), .match_ep_o(match_ep), .match_dir_o(match_dir)
    );

    task automatic cfg_write(input logic [2:0] sel, input logic [15:0] d);
        @(negedge clk);
        tok_valid = 1'b0;
        cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
        if (sel < 3'd4) begin
            m_addr[sel] = d[6:0];
            m_vld[sel]  = d[7];
        end else if (sel == 3'd4) m_tx = d;
        else if (sel == 3'd5) m_rx = d;
        else if (sel == 3'd6) m_all = d[0];
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drives one token in the current negedge slot and predicts the result
    task automatic drive_tok(input logic [3:0] pid, input logic [6:0] a,
                             input logic [3:0] e, input string req);
        exp_t x;
        logic is_in, is_rx, ep_ok, hit;
        logic [2:0] idx;
        is_in = (pid == 4'b1001);
        is_rx = (pid == 4'b0001) || (pid == 4'b1101);
        ep_ok = (is_in && m_tx[e]) || (is_rx && m_rx[e]);
        hit = 1'b0; idx = 3'd0;
        for (int s = 3; s >= 0; s--)
            if (m_vld[s] && m_addr[s] == a) begin hit = 1'b1; idx = 3'(s); end
        if (m_all) idx = 3'd4;
        x.due = cyc + 1;
        x.hit = ep_ok && (hit || m_all);
        x.idx = x.hit ? idx : 3'd0;
        x.ep  = x.hit ? e : 4'd0;
        x.dir = x.hit ? is_in : 1'b0;
        x.req = req;
        q.push_back(x);
        tok_valid = 1'b1; tok_pid = pid; tok_addr = a; tok_ep = e;
    endtask

    task automatic send(input logic [3:0] pid, input logic [6:0] a,
                        input logic [3:0] e, input string req);
        @(negedge clk);
        drive_tok(pid, a, e, req);
        @(negedge clk);
        tok_valid = 1'b0;
        @(negedge clk);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (q.size() > 0 && q[0].due == cyc) begin
                exp_t x;
                x = q.pop_front();
                n_tests++;
                if (match !== x.hit || match_idx !== x.idx ||
                    match_ep !== x.ep || match_dir !== x.dir) begin
                    n_fail++;
                    $display("FAIL %s: got m=%b idx=%0d ep=%0d dir=%b exp m=%b idx=%0d ep=%0d dir=%b",
                             x.req, match, match_idx, match_ep, match_dir,
                             x.hit, x.idx, x.ep, x.dir);
                end
            end else if (match !== 1'b0) begin
                n_tests++; n_fail++;
                $display("FAIL R7: unexpected match got 1 exp 0");
            end
        end
    end

    initial begin
        for (int s = 0; s < 4; s++) begin m_addr[s] = '0; m_vld[s] = 1'b0; end
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                n_tests++;
                if (match !== 1'b0 || match_idx !== 3'd0 || match_ep !== 4'd0 || match_dir !== 1'b0) begin
                    n_fail++;
                    $display("FAIL R9: reset outputs got %b/%0d/%0d/%b exp 0/0/0/0",
                             match, match_idx, match_ep, match_dir);
                end
                // R9: address 0 with reset config must not match
                send(4'b0001, 7'd0, 4'd0, "R9");
                cfg_write(3'd5, 16'hFFFF);
                send(4'b0001, 7'd0, 4'd0, "R9 R2 invalid slot0 holds 0");
                // R1 local and alternate slots
                cfg_write(3'd0, 16'h0080 | 16'd5);
                cfg_write(3'd2, 16'h0080 | 16'd33);
                cfg_write(3'd4, 16'h0006);
                send(4'b0001, 7'd5, 4'd3, "R1 local OUT");
                send(4'b1001, 7'd33, 4'd2, "R1 R4 alternate IN");
                send(4'b1001, 7'd33, 4'd3, "R4 IN ep masked");
                send(4'b1101, 7'd33, 4'd3, "R4 SETUP rx mask");
                send(4'b0001, 7'd99, 4'd1, "R1 no slot");
                // R2 invalid slot with matching address
                cfg_write(3'd3, 16'd70);
                send(4'b0001, 7'd70, 4'd1, "R2 invalid slot3");
                // R3 priority
                cfg_write(3'd1, 16'h0080 | 16'd33);
                cfg_write(3'd3, 16'h0080 | 16'd33);
                send(4'b0001, 7'd33, 4'd4, "R3 lowest of 1,2,3");
                // R5 other pids
                send(4'b0101, 7'd5, 4'd1, "R5 SOF");
                send(4'b1010, 7'd5, 4'd1, "R5 other pid");
                // R8 runtime mask change
                cfg_write(3'd5, 16'h0000);
                send(4'b0001, 7'd5, 4'd3, "R8 rx cleared");
                cfg_write(3'd5, 16'h0008);
                send(4'b0001, 7'd5, 4'd3, "R8 rx re-enabled");
                // R8 token right after write
                @(negedge clk);
                cfg_we = 1'b1; cfg_sel = 3'd4; cfg_data = 16'h0100; m_tx = 16'h0100;
                @(negedge clk);
                cfg_we = 1'b0;
                drive_tok(4'b1001, 7'd5, 4'd8, "R8 next-cycle use");
                @(negedge clk);
                tok_valid = 1'b0;
                @(negedge clk);
                // R7 back-to-back tokens
                @(negedge clk);
                drive_tok(4'b0001, 7'd5, 4'd3, "R7 b2b first");
                @(negedge clk);
                drive_tok(4'b0001, 7'd99, 4'd3, "R7 b2b reject");
                @(negedge clk);
                drive_tok(4'b1001, 7'd33, 4'd8, "R7 b2b third");
                @(negedge clk);
                tok_valid = 1'b0;
                @(negedge clk);
                // R6 receive-all
                cfg_write(3'd6, 16'h0001);
                send(4'b0001, 7'd120, 4'd3, "R6 snoop foreign");
                send(4'b0001, 7'd5, 4'd3, "R6 snoop local idx");
                send(4'b0001, 7'd120, 4'd2, "R6 snoop masked");
                send(4'b1001, 7'd77, 4'd8, "R6 snoop IN");
                cfg_write(3'd6, 16'h0000);
                send(4'b0001, 7'd120, 4'd3, "R6 snoop off");
                repeat (3) @(negedge clk);
                if (q.size() != 0) begin
                    n_tests++; n_fail++;
                    $display("FAIL R7: %0d results missing exp 0", q.size());
                end
            end
            begin
                repeat (20000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL R7: watchdog expired got hang exp finish");
            end
        join_any
        disable fork;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule